// File: doc/BRIEF.md
# Burst-Capable Memory Slave Cycle Controller

This block is the slave side of a 32-bit synchronous expansion-bus memory target. It runs on a fast system clock. Two single-cycle strobes, `bus_rise` and `bus_fall`, mark the rising and falling edges of the slower bus clock. The block decodes the live pipelined word address and the memory/IO status. From that decode it drives its 32-bit-support and burst-support indications straight back, with no latch. When a cycle starts, it holds the target word, lane enables and direction at the bus-clock rise that ends the start strobe. It stretches the cycle through an active-high ready line by a programmable number of bus clocks, and it never holds ready low past a fixed ceiling. Behind the bus side sits a small word array with per-byte write lanes.

The eight top address bits arrive inverted and the remaining 22 arrive true. A cycle is claimed only when the memory status is high and the upper word-address bits match the `BASE_ADDR` window. Write data is taken at the bus-clock rise that ends each transfer, while the command strobe is low. A master may continue with burst transfers by presenting its burst request together with a new address at that rise. Each burst transfer then completes in one bus clock with no wait states.

The controller state machine has four states:
- ST_IDLE: waits for a cycle. Transition *claim*: start is low and the address hits.
- ST_SELECT: start is asserted. Transition *latch*: at the next rise it goes to ST_STALL if ready was pulled low, else to ST_XFER.
- ST_STALL: counts falls. Transition *release*: when the count or the ceiling is reached, ready is raised at that fall and the state moves to ST_XFER.
- ST_XFER: command phase. Transition *finish*: at the next rise it writes when the cycle is a write, then either returns to ST_IDLE or stays in ST_XFER (transition *chain*) when a burst request arrives with a hitting address.

Top module: `xbus_burst_slave`

## Requirements
- R1: `wide_n` and `burst_ok_n` go low in the same cycle, combinationally, when `mem_sel` is 1 and the word address {~addr_top_n, addr_low} has bits [29:AW] equal to BASE_ADDR[31:AW+2]; this is independent of `burst_req_n`. A top byte driven non-inverted misses.
- R2: While `rst` is 1, `wide_n` and `burst_ok_n` are 1, and one clock later `rdy_o` is 1 with the cycle state cleared.
- R3: The word index (word address bits [AW-1:0]), lane enables and direction are captured at the `bus_rise` that ends `cyc_go_n` low. Address changes after that rise do not alter the target.
- R4: On a claim with `wait_cfg` non-zero, `rdy_o` goes low while start is still asserted. With `wait_cfg` zero, `rdy_o` stays 1.
- R5: `rdy_o` returns to 1 only right after a `bus_fall` strobe. The number of falls after capture that see `rdy_o` low equals `wait_cfg`.
- R6: `rdy_o` is never held low for more than WAIT_CAP (20) falls after capture; a larger `wait_cfg` is clipped to 20.
- R7: On a write, at the `bus_rise` ending the transfer with `cyc_cmd_n` low, byte lane n (bits 8n+7:8n) is written only when `lane_n[n]` is 0.
- R8: `rdata` holds the full 32-bit word at the captured index during the command phase.
- R9: `burst_req_n` low with a hitting address at the ending rise captures the new address. The next transfer ends one bus clock later with `rdy_o` held at 1, and each transfer writes its own data.
- R10: A cycle with `mem_sel` 0 or an address outside the window is ignored: `rdy_o` stays 1 and no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous bus reset, active high |
| bus_rise | input | 1 | One-cycle strobe at each bus-clock rising edge |
| bus_fall | input | 1 | One-cycle strobe at each bus-clock falling edge |
| cyc_go_n | input | 1 | Cycle start strobe, active low |
| cyc_cmd_n | input | 1 | Command phase strobe, active low |
| addr_top_n | input | 8 | Address bits 31:24, inverted |
| addr_low | input | 22 | Address bits 23:2, true |
| lane_n | input | 4 | Byte lane enables, active low |
| mem_sel | input | 1 | 1 for memory cycle, 0 for I/O |
| wr_sel | input | 1 | 1 for write, 0 for read |
| burst_req_n | input | 1 | Master burst continuation request, active low |
| wait_cfg | input | CFG_W | Wait states to insert, in bus clocks |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the captured word |
| rdy_o | output | 1 | Ready line, 0 requests a wait state |
| wide_n | output | 1 | 32-bit transfer support, active low |
| burst_ok_n | output | 1 | Burst support, active low |

## Verification
The bench writes a word and then moves the address lines to a neighbouring word right after the capturing rise. A controller that captured late or sampled live would corrupt the neighbour instead of the target. Wait counts of zero, one, several, exactly the ceiling and twice the ceiling are measured at the falling strobes. An off-by-one counter, a release on a rise, or a missing clip would show up as a wrong count or a hung ready line. Mixed lane masks, bursts of four transfers, I/O cycles and out-of-window addresses that alias the same array index expose lane inversion, a burst that inserts waits or drops data, and a decode that ignores the status bit or the inverted top byte.

// File: rtl/xbus_slave_pkg.sv
`timescale 1ns/1ps
package xbus_slave_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_STALL  = 2'd2,
        ST_XFER   = 2'd3
    } slv_state_t;
endpackage

// File: rtl/xbus_addr_decode.sv
`timescale 1ns/1ps
// Live window decode of the pipelined word address; nothing is held here.
module xbus_addr_decode #(
    parameter int          AW        = 4,
    parameter logic [31:0] BASE_ADDR = 32'hC000_0000
) (
    input  logic          rst,
    input  logic [7:0]    addr_top_n,
    input  logic [21:0]   addr_low,
    input  logic          mem_sel,
    output logic          hit,
    output logic [AW-1:0] word_idx
);
    localparam int TAG_W = 30 - AW;

    logic [29:0]      word_addr;
    logic [TAG_W-1:0] base_tag;

    assign base_tag  = BASE_ADDR[31:AW+2];
    assign word_addr = {~addr_top_n, addr_low};
    assign word_idx  = word_addr[AW-1:0];
    assign hit       = mem_sel && !rst && (word_addr[29:AW] == base_tag);
endmodule

// File: rtl/xbus_wait_timer.sv
`timescale 1ns/1ps
// Counts bus-clock falls during a stall; the limit is clipped to the ceiling.
module xbus_wait_timer #(
    parameter int CFG_W    = 6,
    parameter int WAIT_CAP = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg,
    input  logic             tick,
    output logic             expire
);
    localparam int CAP_BITS = $clog2(WAIT_CAP + 1);
    localparam int CNT_W    = (CFG_W > CAP_BITS) ? CFG_W : CAP_BITS;
    localparam logic [CNT_W-1:0] CAP_V = CNT_W'(WAIT_CAP);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cfg_ext;

    assign cfg_ext = CNT_W'(cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= (cfg_ext > CAP_V) ? CAP_V : cfg_ext;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = tick && ((cnt_q + 1'b1) == lim_q);
endmodule

// File: rtl/xbus_word_array.sv
`timescale 1ns/1ps
// Local word store with one write enable per byte lane.
module xbus_word_array #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [3:0]    lane_we,
    input  logic [AW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && lane_we[g]) begin
                mem[idx][8*g +: 8] <= wdata[8*g +: 8];
            end
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/xbus_burst_slave.sv
`timescale 1ns/1ps
module xbus_burst_slave
    import xbus_slave_pkg::*;
#(
    parameter int          AW        = 4,
    parameter logic [31:0] BASE_ADDR = 32'hC000_0000,
    parameter int          CFG_W     = 6,
    parameter int          WAIT_CAP  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_rise,
    input  logic             bus_fall,
    input  logic             cyc_go_n,
    input  logic             cyc_cmd_n,
    input  logic [7:0]       addr_top_n,
    input  logic [21:0]      addr_low,
    input  logic [3:0]       lane_n,
    input  logic             mem_sel,
    input  logic             wr_sel,
    input  logic             burst_req_n,
    input  logic [CFG_W-1:0] wait_cfg,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             rdy_o,
    output logic             wide_n,
    output logic             burst_ok_n
);
    slv_state_t    state_q, state_d;
    logic          hit;
    logic [AW-1:0] live_idx;
    logic [AW-1:0] lat_idx;
    logic [3:0]    lat_lane_n;
    logic          lat_wr;
    logic          rdy_q;
    logic          expire;
    logic          claim, capture, chain, wr_fire, stall_tick;

    xbus_addr_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_dec (
        .rst        (rst),
        .addr_top_n (addr_top_n),
        .addr_low   (addr_low),
        .mem_sel    (mem_sel),
        .hit        (hit),
        .word_idx   (live_idx)
    );

    // Support indications follow the live decode, unlatched.
    assign wide_n     = ~hit;
    assign burst_ok_n = ~hit;

    assign claim      = (state_q == ST_IDLE) && !cyc_go_n && hit;
    assign chain      = (state_q == ST_XFER) && bus_rise && !burst_req_n && hit;
    assign capture    = ((state_q == ST_SELECT) && bus_rise) || chain;
    assign wr_fire    = (state_q == ST_XFER) && bus_rise && !cyc_cmd_n && lat_wr;
    assign stall_tick = (state_q == ST_STALL) && bus_fall;

    xbus_wait_timer #(.CFG_W(CFG_W), .WAIT_CAP(WAIT_CAP)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (claim),
        .cfg    (wait_cfg),
        .tick   (stall_tick),
        .expire (expire)
    );

    xbus_word_array #(.AW(AW)) u_mem (
        .clk     (clk),
        .we      (wr_fire),
        .lane_we (~lat_lane_n),
        .idx     (lat_idx),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (claim)    state_d = ST_SELECT;
            ST_SELECT: if (bus_rise) state_d = rdy_q ? ST_XFER : ST_STALL;
            ST_STALL:  if (expire)   state_d = ST_XFER;
            ST_XFER:   if (bus_rise) state_d = chain ? ST_XFER : ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Registered outputs and captured cycle fields
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q      <= 1'b1;
            lat_idx    <= '0;
            lat_lane_n <= 4'hF;
            lat_wr     <= 1'b0;
        end else begin
            if (claim && (wait_cfg != '0)) rdy_q <= 1'b0;
            else if (expire)               rdy_q <= 1'b1;
            if (capture) begin
                lat_idx    <= live_idx;
                lat_lane_n <= lane_n;
                lat_wr     <= wr_sel;
            end
        end
    end

    assign rdy_o = rdy_q;
endmodule

// File: rtl/xbus_slave_checker.sv
`timescale 1ns/1ps
module xbus_slave_checker #(
    parameter int WAIT_CAP = 20
) (
    input logic clk,
    input logic rst,
    input logic bus_fall,
    input logic cyc_go_n,
    input logic mem_sel,
    input logic rdy_o,
    input logic wide_n,
    input logic burst_ok_n
);
    logic [7:0] low_falls;

    always_ff @(posedge clk) begin
        if (rst || rdy_o)                    low_falls <= '0;
        else if (bus_fall && low_falls != 8'hFF) low_falls <= low_falls + 8'd1;
    end

    assert_quiet_in_reset_R2: assert property (@(posedge clk)
        rst |-> (wide_n && burst_ok_n));

    assert_ready_after_reset_R2: assert property (@(posedge clk)
        rst |=> rdy_o);

    assert_support_needs_memory_R1: assert property (@(posedge clk) disable iff (rst)
        !wide_n |-> mem_sel);

    assert_low_only_on_claim_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_o) |-> ($past(!cyc_go_n) && $past(mem_sel)));

    assert_release_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_o) |-> ($past(bus_fall) || $past(rst)));

    assert_wait_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
        32'(low_falls) <= WAIT_CAP + 1);
endmodule

bind xbus_burst_slave xbus_slave_checker #(.WAIT_CAP(WAIT_CAP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_fall   (bus_fall),
    .cyc_go_n   (cyc_go_n),
    .mem_sel    (mem_sel),
    .rdy_o      (rdy_o),
    .wide_n     (wide_n),
    .burst_ok_n (burst_ok_n)
);

// File: tb/sim_xbus_burst_slave.sv
`timescale 1ns/1ps
module sim_xbus_burst_slave;
    localparam logic [31:0] BASE = 32'hC000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rise = 1'b0, bus_fall = 1'b0;
    logic [1:0]  ph = 2'd0;
    logic        cyc_go_n = 1'b1, cyc_cmd_n = 1'b1;
    logic [7:0]  addr_top_n = 8'hFF;
    logic [21:0] addr_low = '0;
    logic [3:0]  lane_n = 4'hF;
    logic        mem_sel = 1'b0, wr_sel = 1'b0, burst_req_n = 1'b1;
    logic [5:0]  wait_cfg = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdy_o, wide_n, burst_ok_n;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // Bus clock is four system clocks: rise at phase 3, fall at phase 1.
    always @(posedge clk) begin
        ph       <= ph + 2'd1;
        bus_rise <= (ph == 2'd3);
        bus_fall <= (ph == 2'd1);
    end

    xbus_burst_slave u0 (
        .clk(clk), .rst(rst), .bus_rise(bus_rise), .bus_fall(bus_fall),
        .cyc_go_n(cyc_go_n), .cyc_cmd_n(cyc_cmd_n), .addr_top_n(addr_top_n),
        .addr_low(addr_low), .lane_n(lane_n), .mem_sel(mem_sel), .wr_sel(wr_sel),
        .burst_req_n(burst_req_n), .wait_cfg(wait_cfg), .wdata(wdata),
        .rdata(rdata), .rdy_o(rdy_o), .wide_n(wide_n), .burst_ok_n(burst_ok_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_addr(input logic [31:0] a);
        addr_top_n = ~a[31:24];
        addr_low   = a[23:2];
    endtask

    task automatic at_rise;
        do @(negedge clk); while (!bus_rise);
    endtask

    task automatic at_fall;
        do @(negedge clk); while (!bus_fall);
    endtask

    // One single transfer; returns the read data seen at the ending rise.
    task automatic run_cycle(input logic [31:0] a, input logic [3:0] ln, input logic wr,
                             input logic ms, input logic [31:0] wd, input int cfg,
                             input int exp_waits, input string tag, output logic [31:0] rd);
        int waits = 0;
        at_rise;
        @(negedge clk);
        put_addr(a); lane_n = ln; wr_sel = wr; mem_sel = ms; wdata = wd;
        wait_cfg = 6'(cfg); cyc_go_n = 1'b0;
        at_rise;
        check(rdy_o == (exp_waits == 0), {tag, " R4 ready during start"}, 32'(rdy_o), 32'(exp_waits == 0));
        @(negedge clk);
        cyc_go_n = 1'b1; cyc_cmd_n = 1'b0;
        put_addr(a + 32'd4);   // pipelined address moves on (R3)
        forever begin
            at_fall;
            if (rdy_o) break;
            waits++;
            if (waits > 60) break;
        end
        check(waits == exp_waits, {tag, " R5 wait count"}, 32'(waits), 32'(exp_waits));
        at_rise;
        rd = rdata;
        @(negedge clk);
        cyc_cmd_n = 1'b1;
    endtask

    task automatic t_reset;
        rst = 1'b1; mem_sel = 1'b1; put_addr(BASE);
        repeat (6) @(negedge clk);
        check(rdy_o == 1'b1, "R2 ready in reset", 32'(rdy_o), 1);
        check(wide_n == 1'b1 && burst_ok_n == 1'b1, "R2 support lines in reset",
              {30'd0, wide_n, burst_ok_n}, 32'd3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_decode;
        mem_sel = 1'b1; put_addr(BASE + 32'h3C); burst_req_n = 1'b1;
        @(negedge clk);
        check(!wide_n && !burst_ok_n, "R1 hit decode", {30'd0, wide_n, burst_ok_n}, 0);
        burst_req_n = 1'b0;
        @(negedge clk);
        check(!wide_n && !burst_ok_n, "R1 hit with burst request", {30'd0, wide_n, burst_ok_n}, 0);
        burst_req_n = 1'b1; mem_sel = 1'b0;
        @(negedge clk);
        check(wide_n && burst_ok_n, "R1 R10 io status misses", {30'd0, wide_n, burst_ok_n}, 3);
        mem_sel = 1'b1; addr_top_n = 8'hC0;   // top byte not inverted
        @(negedge clk);
        check(wide_n && burst_ok_n, "R1 inverted top byte", {30'd0, wide_n, burst_ok_n}, 3);
    endtask

    task automatic t_write_lanes;
        logic [31:0] rd;
        run_cycle(BASE, 4'h0, 1'b1, 1'b1, 32'h1122_3344, 0, 0, "wr0", rd);
        run_cycle(BASE, 4'h0, 1'b0, 1'b1, 32'h0, 0, 0, "rd0", rd);
        check(rd == 32'h1122_3344, "R7 R8 full word", rd, 32'h1122_3344);
        run_cycle(BASE, 4'b1010, 1'b1, 1'b1, 32'hAABB_CCDD, 2, 2, "wr_lanes", rd);
        run_cycle(BASE, 4'h0, 1'b0, 1'b1, 32'h0, 0, 0, "rd_lanes", rd);
        check(rd == 32'h11BB_33DD, "R7 lane mask", rd, 32'h11BB_33DD);
    endtask

    task automatic t_capture;
        logic [31:0] rd;
        run_cycle(BASE + 32'h10, 4'h0, 1'b1, 1'b1, 32'h0, 0, 0, "clr4", rd);
        run_cycle(BASE + 32'h0C, 4'h0, 1'b1, 1'b1, 32'hCAFE_F00D, 1, 1, "wr3", rd);
        run_cycle(BASE + 32'h0C, 4'h0, 1'b0, 1'b1, 32'h0, 0, 0, "rd3", rd);
        check(rd == 32'hCAFE_F00D, "R3 target word", rd, 32'hCAFE_F00D);
        run_cycle(BASE + 32'h10, 4'h0, 1'b0, 1'b1, 32'h0, 0, 0, "rd4", rd);
        check(rd == 32'h0, "R3 neighbour untouched", rd, 32'h0);
    endtask

    task automatic t_waits;
        logic [31:0] rd;
        run_cycle(BASE, 4'h0, 1'b0, 1'b1, 32'h0, 1, 1, "w1", rd);
        run_cycle(BASE, 4'h0, 1'b0, 1'b1, 32'h0, 3, 3, "w3", rd);
        run_cycle(BASE, 4'h0, 1'b0, 1'b1, 32'h0, 7, 7, "w7", rd);
        check(rd == 32'h11BB_33DD, "R8 read after waits", rd, 32'h11BB_33DD);
    endtask

    task automatic t_cap;
        logic [31:0] rd;
        run_cycle(BASE, 4'h0, 1'b0, 1'b1, 32'h0, 20, 20, "R6 at ceiling", rd);
        run_cycle(BASE, 4'h0, 1'b0, 1'b1, 32'h0, 40, 20, "R6 clipped", rd);
    endtask

    task automatic t_ignore;
        logic [31:0] rd;
        run_cycle(BASE + 32'h1000_0000, 4'h0, 1'b1, 1'b1, 32'hDEAD_BEEF, 3, 0, "R10 window miss", rd);
        run_cycle(BASE, 4'h0, 1'b1, 1'b0, 32'hDEAD_BEEF, 3, 0, "R10 io cycle", rd);
        run_cycle(BASE, 4'h0, 1'b0, 1'b1, 32'h0, 0, 0, "rd_ign", rd);
        check(rd == 32'h11BB_33DD, "R10 word unchanged", rd, 32'h11BB_33DD);
    endtask

    task automatic t_burst;
        logic [31:0] rd;
        logic [31:0] dat [4];
        for (int k = 0; k < 4; k++) dat[k] = 32'h5A00_0000 + 32'(k * 32'h0101);
        at_rise;
        @(negedge clk);
        put_addr(BASE + 32'h20); lane_n = 4'h0; wr_sel = 1'b1; mem_sel = 1'b1;
        wdata = dat[0]; wait_cfg = 6'd0; cyc_go_n = 1'b0;
        at_rise;
        @(negedge clk);
        cyc_go_n = 1'b1; cyc_cmd_n = 1'b0;
        for (int k = 1; k < 4; k++) begin
            at_fall;
            check(rdy_o == 1'b1, "R9 no wait in burst", 32'(rdy_o), 1);
            at_rise;
            burst_req_n = 1'b0; put_addr(BASE + 32'h20 + 32'(4 * k));
            @(negedge clk);
            wdata = dat[k];
        end
        at_fall;
        check(rdy_o == 1'b1, "R9 no wait on last", 32'(rdy_o), 1);
        at_rise;
        burst_req_n = 1'b1;
        @(negedge clk);
        cyc_cmd_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            run_cycle(BASE + 32'h20 + 32'(4 * k), 4'h0, 1'b0, 1'b1, 32'h0, 0, 0, "rd_burst", rd);
            check(rd == dat[k], "R9 burst data", rd, dat[k]);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_decode;
        t_write_lanes;
        t_capture;
        t_waits;
        t_cap;
        t_ignore;
        t_burst;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule